// File: doc/BRIEF.md
# Indirect Jump Target Ranking Table

This block sits beside the front-end predictor and keeps a short frequency history of the targets seen by hard-to-predict indirect jumps. Each table row holds three candidate targets, each with a small saturating counter. A row is selected by hashing the jump's address with the last target that jump took. The block only counts and ranks. The target words are modelled as a side array that shares the row index, and predication itself is outside this block.

A lookup returns the two highest-ranked targets one cycle later, with a mask that marks which of them are backed by a nonzero count. When one target clearly outweighs the others, the override flag tells the front end to use that target in place of its normal prediction. When the jump is flagged low-confidence, two ranked targets exist and no override applies, the dual-path request tells the front end to fetch and predicate both paths. An update port reports each resolved target. A matching slot is reinforced. A new target replaces the weakest slot.

Top module: `jump_target_rank`

## Requirements
- R1: After reset every counter is zero and the registered outputs (response valid, both targets, mask, override, dual-path request) are all zero.
- R2: The row index is bits [IDX_W+1:2] of the jump address XOR bits [IDX_W+1:2] of the last target. Two address/last-target pairs with the same index share one row.
- R3: A lookup presented in one cycle produces exactly one response, with the response valid flag high, in the next cycle.
- R4: On update, the lowest-numbered slot with a nonzero count and a stored target equal to the resolved target has its count raised by one. If no slot matches, the slot with the smallest count (lowest slot number on ties) takes the new target with a count of 1, and the other slots are left unchanged.
- R5: Counters are 3 bits wide. When a matching counter already holds 7, every counter in the row is first halved (shift right by one), and then the matching counter is raised by one.
- R6: The first output is the target of the slot with the largest count. The second output is the largest among the remaining slots. Equal counts favour the lower slot number.
- R7: Mask bit 0 (first) and bit 1 (second) are set only when the slot chosen for that position has a nonzero count. A target output whose mask bit is clear reads zero.
- R8: Override is high when the first slot's count is at least 4 and the other two counts add up to at most 1.
- R9: The dual-path request is high only when the lookup's low-confidence flag was set, both mask bits are set and override is low. At most two targets are ever offered.
- R10: An update that lands on the same row in the same cycle as a lookup does not affect that lookup's response. The lookup sees the row as it was before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | PC_W | Address of the jump being looked up |
| lk_last | input | TGT_W | Most recent target of that jump |
| lk_lowconf | input | 1 | The jump's prediction is low-confidence |
| up_valid | input | 1 | Update request |
| up_pc | input | PC_W | Address of the resolved jump |
| up_last | input | TGT_W | Last target used to index the update |
| up_target | input | TGT_W | Resolved actual target |
| rsp_valid | output | 1 | Response is present |
| rsp_first | output | TGT_W | Most frequent target |
| rsp_second | output | TGT_W | Second most frequent target |
| rsp_mask | output | 2 | Bit 0: first is valid. Bit 1: second is valid |
| rsp_override | output | 1 | A single target dominates; use it in place of the normal prediction |
| rsp_dual | output | 1 | Fetch and predicate both returned targets |

## Verification
A bad counter or a misplaced target cannot be seen on its own. It shows up on the next lookup of the same row, one cycle after that lookup is issued, as a swapped first/second pair, a wrong mask bit, or an override or dual-path flag that flips. The halving step is the slowest fault to reveal: a bad ageing rule shifts the ranking only after a counter has saturated and other targets then keep arriving. For that reason the bench drives long runs on a few shared rows and compares every response against a reference model of the counters. Same-cycle lookup and update to one row is driven on purpose, so that any bypass would change a visible response.

// File: rtl/jtr_pkg.sv
package jtr_pkg;
   // Fold an address and a last target into a row index (drops the 2 alignment bits).
   function automatic logic [15:0] jtr_row_hash(input logic [63:0] pc,
                                                input logic [63:0] last,
                                                input int unsigned idx_w);
      logic [63:0] mix;
      logic [15:0] keep;
      mix  = (pc >> 2) ^ (last >> 2);
      keep = 16'((64'd1 << idx_w) - 64'd1);
      return mix[15:0] & keep;
   endfunction
endpackage

// File: rtl/jtr_store.sv
module jtr_store #(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned NSLOT = 3,
   parameter int unsigned TGT_W = 32,
   parameter int unsigned CNT_W = 3,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [AW-1:0]                     lk_idx,
   output logic [NSLOT-1:0][TGT_W-1:0]       lk_tgt,
   output logic [NSLOT-1:0][CNT_W-1:0]       lk_cnt,
   input  logic [AW-1:0]                     up_idx,
   output logic [NSLOT-1:0][TGT_W-1:0]       up_tgt,
   output logic [NSLOT-1:0][CNT_W-1:0]       up_cnt,
   input  logic                              wr_en,
   input  logic [AW-1:0]                     wr_idx,
   input  logic [NSLOT-1:0][TGT_W-1:0]       wr_tgt,
   input  logic [NSLOT-1:0][CNT_W-1:0]       wr_cnt
);
   logic [NSLOT-1:0][TGT_W-1:0] tmem [DEPTH];
   logic [NSLOT-1:0][CNT_W-1:0] cmem [DEPTH];

   // Counters carry reset; target words only matter behind a nonzero count.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < DEPTH; e++) cmem[e] <= '0;
      end else if (wr_en) begin
         cmem[wr_idx] <= wr_cnt;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) tmem[wr_idx] <= wr_tgt;
   end

   assign lk_tgt = tmem[lk_idx];
   assign lk_cnt = cmem[lk_idx];
   assign up_tgt = tmem[up_idx];
   assign up_cnt = cmem[up_idx];

   // R4: a written row always carries at least one live count
   p_write_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_cnt != '0));
endmodule

// File: rtl/jtr_update.sv
module jtr_update #(
   parameter int unsigned NSLOT     = 3,
   parameter int unsigned TGT_W     = 32,
   parameter int unsigned CNT_W     = 3,
   parameter bit          AGE_HALVE = 1'b1,
   localparam int unsigned SW       = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
   input  logic [NSLOT-1:0][TGT_W-1:0] cur_tgt,
   input  logic [NSLOT-1:0][CNT_W-1:0] cur_cnt,
   input  logic [TGT_W-1:0]            act,
   output logic [NSLOT-1:0][TGT_W-1:0] nxt_tgt,
   output logic [NSLOT-1:0][CNT_W-1:0] nxt_cnt
);
   localparam logic [CNT_W-1:0] CMAX = '1;
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] BUMP = AGE_HALVE ? ONE : '0;

   logic [NSLOT-1:0][CNT_W-1:0] aged_cnt;
   logic          hit;
   logic [SW-1:0] hidx;
   logic [SW-1:0] vic;

   // Saturation policy: halve the whole row, or simply hold at the ceiling.
   generate
      if (AGE_HALVE) begin : g_halve
         for (genvar s = 0; s < NSLOT; s++) begin : g_slot
            assign aged_cnt[s] = cur_cnt[s] >> 1;
         end
      end else begin : g_hold
         assign aged_cnt = cur_cnt;
      end
   endgenerate

   always_comb begin
      hit  = 1'b0;
      hidx = '0;
      for (int i = 0; i < NSLOT; i++) begin
         if (!hit && (cur_cnt[i] != '0) && (cur_tgt[i] == act)) begin
            hit  = 1'b1;
            hidx = SW'(i);
         end
      end
      vic = '0;
      for (int i = 1; i < NSLOT; i++) begin
         if (cur_cnt[i] < cur_cnt[vic]) vic = SW'(i);
      end
      nxt_tgt = cur_tgt;
      nxt_cnt = cur_cnt;
      if (hit) begin
         if (cur_cnt[hidx] == CMAX) begin
            nxt_cnt       = aged_cnt;
            nxt_cnt[hidx] = aged_cnt[hidx] + BUMP;
         end else begin
            nxt_cnt[hidx] = cur_cnt[hidx] + ONE;
         end
      end else begin
         nxt_tgt[vic] = act;
         nxt_cnt[vic] = ONE;
      end
   end

   // R4: the resolved target always ends up held by a live slot
   always_comb begin
      if (!$isunknown(act) && !$isunknown(cur_cnt)) begin
         p_target_kept_r4: assert ((hit ? nxt_cnt[hidx] : nxt_cnt[vic]) != '0);
      end
   end
endmodule

// File: rtl/jtr_rank.sv
module jtr_rank #(
   parameter int unsigned NSLOT    = 3,
   parameter int unsigned TGT_W    = 32,
   parameter int unsigned CNT_W    = 3,
   parameter int unsigned OVR_MIN  = 4,
   parameter int unsigned OVR_REST = 1,
   localparam int unsigned SW      = $clog2(NSLOT),
   localparam int unsigned SUM_W   = CNT_W + SW + 1
) (
   input  logic [NSLOT-1:0][TGT_W-1:0] tgt,
   input  logic [NSLOT-1:0][CNT_W-1:0] cnt,
   output logic [TGT_W-1:0]            first,
   output logic [TGT_W-1:0]            second,
   output logic [1:0]                  mask,
   output logic                        dominant
);
   logic [SW-1:0]    best;
   logic [SW-1:0]    next;
   logic [SUM_W-1:0] total;
   logic [SUM_W-1:0] rest;

   always_comb begin
      best  = '0;
      total = '0;
      for (int i = 0; i < NSLOT; i++) begin
         total = total + SUM_W'(cnt[i]);
         if (cnt[i] > cnt[best]) best = SW'(i);
      end
      next = (best == '0) ? SW'(1) : '0;
      for (int i = 0; i < NSLOT; i++) begin
         if ((SW'(i) != best) && (cnt[i] > cnt[next])) next = SW'(i);
      end
      rest     = total - SUM_W'(cnt[best]);
      mask[0]  = (cnt[best] != '0);
      mask[1]  = (cnt[next] != '0);
      first    = mask[0] ? tgt[best] : '0;
      second   = mask[1] ? tgt[next] : '0;
      dominant = mask[0] && (SUM_W'(cnt[best]) >= SUM_W'(OVR_MIN)) &&
                 (rest <= SUM_W'(OVR_REST));
   end

   // R6: the two chosen slots differ and are ordered by count
   always_comb begin
      if (!$isunknown(cnt)) begin
         p_rank_order_r6: assert ((best != next) && (cnt[best] >= cnt[next]));
      end
   end
endmodule

// File: rtl/jump_target_rank.sv
module jump_target_rank #(
   parameter int unsigned PC_W      = 32,
   parameter int unsigned TGT_W     = 32,
   parameter int unsigned IDX_W     = 6,
   parameter int unsigned NSLOT     = 3,
   parameter int unsigned CNT_W     = 3,
   parameter int unsigned OVR_MIN   = 4,
   parameter int unsigned OVR_REST  = 1,
   parameter bit          AGE_HALVE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lk_valid,
   input  logic [PC_W-1:0]  lk_pc,
   input  logic [TGT_W-1:0] lk_last,
   input  logic             lk_lowconf,
   input  logic             up_valid,
   input  logic [PC_W-1:0]  up_pc,
   input  logic [TGT_W-1:0] up_last,
   input  logic [TGT_W-1:0] up_target,
   output logic             rsp_valid,
   output logic [TGT_W-1:0] rsp_first,
   output logic [TGT_W-1:0] rsp_second,
   output logic [1:0]       rsp_mask,
   output logic             rsp_override,
   output logic             rsp_dual
);
   import jtr_pkg::*;

   localparam int unsigned DEPTH = 1 << IDX_W;

   generate
      if (IDX_W < 1 || IDX_W > 12) begin : g_bad_idx
         $error("IDX_W must be 1..12");
      end
      if (NSLOT < 2 || NSLOT > 4) begin : g_bad_slot
         $error("NSLOT must be 2..4");
      end
      if (PC_W < IDX_W + 2 || TGT_W < IDX_W + 2 || PC_W > 64 || TGT_W > 64) begin : g_bad_w
         $error("address widths must cover the index bits and fit 64");
      end
      if (OVR_MIN > (1 << CNT_W) - 1) begin : g_bad_ovr
         $error("OVR_MIN exceeds counter range");
      end
   endgenerate

   logic [IDX_W-1:0] lk_idx;
   logic [IDX_W-1:0] up_idx;
   assign lk_idx = IDX_W'(jtr_row_hash(64'(lk_pc), 64'(lk_last), IDX_W));
   assign up_idx = IDX_W'(jtr_row_hash(64'(up_pc), 64'(up_last), IDX_W));

   logic [NSLOT-1:0][TGT_W-1:0] lk_tgt, up_tgt, nx_tgt;
   logic [NSLOT-1:0][CNT_W-1:0] lk_cnt, up_cnt, nx_cnt;

   jtr_store #(.DEPTH(DEPTH), .NSLOT(NSLOT), .TGT_W(TGT_W), .CNT_W(CNT_W)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .lk_idx (lk_idx),
      .lk_tgt (lk_tgt),
      .lk_cnt (lk_cnt),
      .up_idx (up_idx),
      .up_tgt (up_tgt),
      .up_cnt (up_cnt),
      .wr_en  (up_valid),
      .wr_idx (up_idx),
      .wr_tgt (nx_tgt),
      .wr_cnt (nx_cnt)
   );

   jtr_update #(.NSLOT(NSLOT), .TGT_W(TGT_W), .CNT_W(CNT_W), .AGE_HALVE(AGE_HALVE)) u_update (
      .cur_tgt (up_tgt),
      .cur_cnt (up_cnt),
      .act     (up_target),
      .nxt_tgt (nx_tgt),
      .nxt_cnt (nx_cnt)
   );

   logic [TGT_W-1:0] rk_first, rk_second;
   logic [1:0]       rk_mask;
   logic             rk_dom;

   jtr_rank #(.NSLOT(NSLOT), .TGT_W(TGT_W), .CNT_W(CNT_W),
              .OVR_MIN(OVR_MIN), .OVR_REST(OVR_REST)) u_rank (
      .tgt      (lk_tgt),
      .cnt      (lk_cnt),
      .first    (rk_first),
      .second   (rk_second),
      .mask     (rk_mask),
      .dominant (rk_dom)
   );

   // Registered response; the row read here predates any same-cycle write.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_first    <= '0;
         rsp_second   <= '0;
         rsp_mask     <= '0;
         rsp_override <= 1'b0;
         rsp_dual     <= 1'b0;
      end else begin
         rsp_valid <= lk_valid;
         if (lk_valid) begin
            rsp_first    <= rk_first;
            rsp_second   <= rk_second;
            rsp_mask     <= rk_mask;
            rsp_override <= rk_dom;
            rsp_dual     <= lk_lowconf && (rk_mask == 2'b11) && !rk_dom;
         end
      end
   end

   // R3: one response per lookup, one cycle later
   p_rsp_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> rsp_valid);
   p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !rsp_valid);
   // R7: second can only be valid when first is
   p_mask_ordered_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_mask[1] |-> rsp_mask[0]);
   // R8: override always names a live first target
   p_override_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_override |-> rsp_mask[0]);
   // R9: dual-path only with two live targets and no override
   p_dual_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_dual |-> (!rsp_override && rsp_mask == 2'b11));
endmodule

// File: tb/jump_target_rank_bench.sv
module jump_target_rank_bench;
   localparam int ROWS = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_pc = '0;
   logic [31:0] lk_last = '0;
   logic        lk_lowconf = 1'b0;
   logic        up_valid = 1'b0;
   logic [31:0] up_pc = '0;
   logic [31:0] up_last = '0;
   logic [31:0] up_target = '0;
   logic        rsp_valid;
   logic [31:0] rsp_first, rsp_second;
   logic [1:0]  rsp_mask;
   logic        rsp_override, rsp_dual;

   always #10 clk = ~clk;

   jump_target_rank u_jump_target_rank (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_last(lk_last), .lk_lowconf(lk_lowconf),
      .up_valid(up_valid), .up_pc(up_pc), .up_last(up_last), .up_target(up_target),
      .rsp_valid(rsp_valid), .rsp_first(rsp_first), .rsp_second(rsp_second),
      .rsp_mask(rsp_mask), .rsp_override(rsp_override), .rsp_dual(rsp_dual)
   );

   typedef struct {
      logic [31:0] first;
      logic [31:0] second;
      logic [1:0]  mask;
      logic        ovr;
      logic        dual;
      string       tag;
   } exp_t;

   exp_t q[$];
   int   total = 0;
   int   bad = 0;
   bit   finished = 0;

   int unsigned m_cnt [ROWS][3];
   logic [31:0] m_tgt [ROWS][3];

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   function automatic int row(input logic [31:0] pc, input logic [31:0] last);
      return int'(((pc >> 2) ^ (last >> 2)) & 32'd63);
   endfunction

   function automatic exp_t predict(input int r, input bit lowc, input string tag);
      exp_t e;
      int b, n, rest;
      b = 0;
      for (int i = 1; i < 3; i++) if (m_cnt[r][i] > m_cnt[r][b]) b = i;
      n = (b == 0) ? 1 : 0;
      for (int i = 0; i < 3; i++) if (i != b && m_cnt[r][i] > m_cnt[r][n]) n = i;
      rest = int'(m_cnt[r][0] + m_cnt[r][1] + m_cnt[r][2] - m_cnt[r][b]);
      e.mask   = {m_cnt[r][n] != 0, m_cnt[r][b] != 0};
      e.first  = e.mask[0] ? m_tgt[r][b] : 32'd0;
      e.second = e.mask[1] ? m_tgt[r][n] : 32'd0;
      e.ovr    = e.mask[0] && m_cnt[r][b] >= 4 && rest <= 1;
      e.dual   = lowc && e.mask == 2'b11 && !e.ovr;
      e.tag    = tag;
      return e;
   endfunction

   task automatic model_update(input int r, input logic [31:0] a);
      int h, v;
      h = -1;
      for (int i = 0; i < 3; i++) if (h < 0 && m_cnt[r][i] != 0 && m_tgt[r][i] == a) h = i;
      if (h >= 0) begin
         if (m_cnt[r][h] == 7) begin
            for (int i = 0; i < 3; i++) m_cnt[r][i] = m_cnt[r][i] / 2;
         end
         m_cnt[r][h] = m_cnt[r][h] + 1;
      end else begin
         v = 0;
         for (int i = 1; i < 3; i++) if (m_cnt[r][i] < m_cnt[r][v]) v = i;
         m_tgt[r][v] = a;
         m_cnt[r][v] = 1;
      end
   endtask

   // Driver: one cycle of stimulus; predictions use the row before this cycle's update.
   task automatic step(input bit lkv, input logic [31:0] lpc, input logic [31:0] llast,
                       input bit lowc, input bit upv, input logic [31:0] upc,
                       input logic [31:0] ulast, input logic [31:0] act, input string tag);
      @(negedge clk);
      lk_valid = lkv; lk_pc = lpc; lk_last = llast; lk_lowconf = lowc;
      up_valid = upv; up_pc = upc; up_last = ulast; up_target = act;
      if (lkv) q.push_back(predict(row(lpc, llast), lowc, tag));
      if (upv) model_update(row(upc, ulast), act);
   endtask

   task automatic upd(input logic [31:0] pc, input logic [31:0] last, input logic [31:0] a);
      step(0, 0, 0, 0, 1, pc, last, a, "");
   endtask

   task automatic look(input logic [31:0] pc, input logic [31:0] last, input bit lowc,
                       input string tag);
      step(1, pc, last, lowc, 0, 0, 0, 0, tag);
   endtask

   task automatic idle();
      step(0, 0, 0, 0, 0, 0, 0, 0, "");
   endtask

   // Monitor: compare each response against the oldest pending prediction.
   always @(negedge clk) begin
      if (rst_n && rsp_valid && !finished) begin
         if (q.size() == 0) begin
            check(0, "R3 response without lookup", 32'd1, 32'd0);
         end else begin
            exp_t e;
            e = q.pop_front();
            check(rsp_first == e.first, {e.tag, " first"}, rsp_first, e.first);
            check(rsp_second == e.second, {e.tag, " second"}, rsp_second, e.second);
            check(rsp_mask == e.mask, {e.tag, " mask"}, 32'(rsp_mask), 32'(e.mask));
            check(rsp_override == e.ovr, {e.tag, " override"}, 32'(rsp_override), 32'(e.ovr));
            check(rsp_dual == e.dual, {e.tag, " dual"}, 32'(rsp_dual), 32'(e.dual));
         end
      end
   end

   localparam logic [31:0] P = 32'h0000_1000;
   localparam logic [31:0] L = 32'h0000_2000;
   localparam logic [31:0] TA = 32'hA000_0040;
   localparam logic [31:0] TB = 32'hB000_0080;
   localparam logic [31:0] TC = 32'hC000_00C0;
   localparam logic [31:0] TD = 32'hD000_0100;

   initial begin
      for (int r = 0; r < ROWS; r++)
         for (int s = 0; s < 3; s++) begin m_cnt[r][s] = 0; m_tgt[r][s] = '0; end
      repeat (3) @(negedge clk);
      // R1: outputs clear under reset
      check(rsp_valid == 0 && rsp_mask == 0 && rsp_override == 0 && rsp_dual == 0 &&
            rsp_first == 0 && rsp_second == 0, "R1 reset outputs", 32'(rsp_mask), 0);
      rst_n = 1'b1;
      idle();
      look(P, L, 1, "R1 empty row");
      idle();
      // R4 / R8: grow one target until it dominates
      repeat (3) upd(P, L, TA);
      look(P, L, 0, "R8 count3 no override");
      upd(P, L, TA);
      look(P, L, 1, "R8 count4 override");
      upd(P, L, TB);
      look(P, L, 1, "R8 rest1 still override");
      upd(P, L, TC);
      look(P, L, 1, "R9 rest2 dual path");
      look(P, L, 0, "R9 high confidence no dual");
      // R6: tie between B and C favours lower slot, then C overtakes B
      upd(P, L, TC);
      look(P, L, 0, "R6 C above B");
      // R4: new target D replaces the weakest slot (B, count 1)
      upd(P, L, TD);
      look(P, L, 0, "R4 replacement");
      // R5: saturate A and keep going so halving happens
      repeat (6) upd(P, L, TA);
      look(P, L, 0, "R5 after halving");
      repeat (4) upd(P, L, TA);
      look(P, L, 1, "R5 second halving");
      // R2: alias pair on the same row, and a neighbour row that stays empty
      look(P ^ 32'h14, L ^ 32'h14, 1, "R2 alias shares row");
      look(P ^ 32'h4, L, 1, "R2 other row empty");
      // R10: same-cycle lookup and update on one row, then visible next cycle
      step(1, P ^ 32'h8, L, 1, 1, P ^ 32'h8, L, TB, "R10 same cycle no bypass");
      look(P ^ 32'h8, L, 1, "R10 visible next cycle");
      // R7: second slot stays invalid while only one target is known
      look(P ^ 32'h8, L, 0, "R7 single target mask");
      // R3 and all ranking rules: random traffic on a few shared rows
      for (int k = 0; k < 600; k++) begin
         logic [31:0] pcs, lst, tg;
         pcs = P + 32'((($urandom % 4)) << 2);
         lst = L + 32'((($urandom % 2)) << 3);
         tg  = 32'hE000_0000 + 32'(($urandom % 5) << 4);
         step(($urandom % 2) == 0, pcs, lst, ($urandom % 2) == 1,
              ($urandom % 3) != 0, pcs ^ 32'(($urandom % 2) << 2), lst, tg,
              "R6 random traffic");
      end
      idle();
      idle();
      check(q.size() == 0, "R3 missing responses", 32'(q.size()), 0);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         check(0, "R3 watchdog expired", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule